// File: doc/BRIEF.md
# Delayed Adjacent-Pixel Coincidence Trigger

This block pairs single hits from a hexagonal detector of 127 pixels into coincidence events. Each hit comes in as a one-cycle strobe carrying a pixel number and a class: prompt for the fast particle, delayed for the slow one. A free-running tick counter (10 ns per tick) is also supplied every cycle. A prompt hit opens a time window that is remembered in a small table. A later delayed hit closes that window only when two conditions hold. The delayed pixel must be the prompt pixel or one of its six hexagonal neighbours. The elapsed time must lie between 1200 and 4000 ticks.

Each closed pair gives a one-cycle coincidence record. The record carries the prompt pixel, the delayed pixel and the delay in ticks. Every accepted hit is counted as a single. When a prompt hit finds the table full, it evicts the oldest window and bumps an overflow count. The block sits after the per-pixel discriminators and before event readout.

Top module: `coinc_trigger`

## Requirements
- R1: Pixels are numbered 0 to 126 row by row over a hexagon of radius 6 in axial coordinates. Row r runs from -6 to 6 and holds 13-|r| pixels in increasing q order. A delayed hit can pair only with a window opened in the same pixel or in a pixel whose axial offset (dq, dr) satisfies |dq|<=1, |dr|<=1 and |dq+dr|<=1. Neighbour slots that fall outside the hexagon hold code 127 and never match.
- R2: The delay is (delayed timestamp - prompt timestamp) modulo 2^32. A pair is formed only when 1200 <= delay <= 4000, with both bounds included.
- R3: A prompt hit (hit_cls = 0) opens a window in the lowest-numbered free slot of a 4-slot table. At most one window opens per cycle, and four windows can be open at once.
- R4: A pair is reported on the cycle after the delayed hit. coin_vld is high for that one cycle, with the prompt pixel, the delayed pixel and the delay in ticks.
- R5: coin_vld is raised only in the cycle after an accepted delayed hit (hit_cls = 1). Prompt hits never produce a record.
- R6: When several open windows qualify, the one with the largest elapsed time wins (ties go to the lowest slot). That window is closed, so it cannot pair again.
- R7: A window whose elapsed time exceeds 4000 ticks is freed. Its slot is available to a new prompt hit without counting an overflow.
- R8: singles_cnt rises by one for every accepted hit of either class.
- R9: A prompt hit that finds all four slots holding live windows overwrites the one with the largest elapsed time and raises ovf_cnt by one. Delayed hits never change ovf_cnt.
- R10: A hit with a pixel number of 127 or above is ignored. It opens no window, pairs with nothing and is not counted.
- R11: After reset, coin_vld is 0, both counters are 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts | input | 32 | Free-running timestamp in 10 ns ticks |
| hit_vld | input | 1 | Hit strobe, one cycle per hit |
| hit_pix | input | 7 | Pixel number of the hit |
| hit_cls | input | 1 | Hit class: 0 prompt, 1 delayed |
| coin_vld | output | 1 | One-cycle coincidence record valid |
| coin_prompt_pix | output | 7 | Pixel of the prompt hit in the record |
| coin_delayed_pix | output | 7 | Pixel of the delayed hit in the record |
| coin_delay | output | 12 | Delay between the two hits in ticks |
| singles_cnt | output | 16 | Count of accepted hits |
| ovf_cnt | output | 16 | Count of windows evicted from a full table |

## Verification
Some properties are checked by assertions on every cycle:
- any reported delay lies inside the window;
- a record follows only a delayed hit;
- at most one window opens per cycle;
- a paired window is closed;
- an expired slot is cleared unless it is refilled;
- the counters hold still on idle cycles, delayed hits and out-of-range pixels.

Other behaviour only the bench scenarios can show. These are the neighbour relation across every prompt and delayed pixel pair, the exact window edges, which window wins when several qualify, and which window a full table gives up.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

  typedef enum logic {
    CLS_PROMPT  = 1'b0,
    CLS_DELAYED = 1'b1
  } hit_cls_e;

  // centre plus six hexagonal neighbours
  localparam int NSLOT = 7;

  function automatic int hex_pixels(int rings);
    return 3 * rings * (rings + 1) + 1;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int row_qlo(int rings, int row);
    return (row < 0) ? (-rings - row) : -rings;
  endfunction

  function automatic int row_base(int rings, int row);
    int acc;
    acc = 0;
    for (int r = -rings; r < row; r++) acc += 2 * rings + 1 - iabs(r);
    return acc;
  endfunction

  // pixel index of neighbour 'slot' of pixel 'pix'; off-array gives hex_pixels()
  function automatic int hex_neighbour(int rings, int pix, int slot);
    int rem, q, r, len, q2, r2;
    rem = pix; q = 0; r = 0;
    for (int row = -rings; row <= rings; row++) begin
      len = 2 * rings + 1 - iabs(row);
      if (rem >= 0 && rem < len) begin
        r = row;
        q = row_qlo(rings, row) + rem;
      end
      rem -= len;
    end
    q2 = q; r2 = r;
    case (slot)
      1: q2 = q + 1;
      2: q2 = q - 1;
      3: r2 = r + 1;
      4: r2 = r - 1;
      5: begin q2 = q + 1; r2 = r - 1; end
      6: begin q2 = q - 1; r2 = r + 1; end
      default: ;
    endcase
    if (iabs(q2) > rings || iabs(r2) > rings || iabs(q2 + r2) > rings)
      return hex_pixels(rings);
    return row_base(rings, r2) + q2 - row_qlo(rings, r2);
  endfunction

endpackage

// File: rtl/hex_nbr_rom.sv
module hex_nbr_rom #(
  parameter int RINGS = 6,
  parameter int NPIX  = 127,
  parameter int PIX_W = 7
) (
  input  logic [PIX_W-1:0]                           pix,
  output logic [coinc_pkg::NSLOT-1:0][PIX_W-1:0]     nbr
);
  localparam int NSLOT = coinc_pkg::NSLOT;

  logic [NPIX-1:0][NSLOT-1:0][PIX_W-1:0] rom;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam int V = coinc_pkg::hex_neighbour(RINGS, p, s);
      assign rom[p][s] = PIX_W'(V);
    end
  end

  assign nbr = (32'(pix) < NPIX) ? rom[pix] : {NSLOT{PIX_W'(NPIX)}};
endmodule

// File: rtl/oldest_pick.sv
module oldest_pick #(
  parameter int DEPTH = 4,
  parameter int AGE_W = 32,
  parameter int IDX_W = 2
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [AGE_W-1:0] age [DEPTH],
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [AGE_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cand[i] && (!found || age[i] > best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = age[i];
      end
    end
  end
endmodule

// File: rtl/window_table.sv
module window_table #(
  parameter int DEPTH   = 4,
  parameter int TS_W    = 32,
  parameter int PIX_W   = 7,
  parameter int MIN_DLY = 1200,
  parameter int MAX_DLY = 4000,
  parameter int DLY_W   = 12
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [TS_W-1:0]                        ts,
  input  logic                                   acc_vld,
  input  logic                                   is_dly,
  input  logic [PIX_W-1:0]                       hit_pix,
  input  logic [coinc_pkg::NSLOT-1:0][PIX_W-1:0] nbr,
  output logic                                   match_vld,
  output logic [PIX_W-1:0]                       match_pix,
  output logic [DLY_W-1:0]                       match_dly,
  output logic                                   ovf_hit
);
  localparam int NSLOT = coinc_pkg::NSLOT;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q;
  logic [PIX_W-1:0] pix_q [DEPTH];
  logic [TS_W-1:0]  ts_q  [DEPTH];
  logic [TS_W-1:0]  age   [DEPTH];
  logic [DEPTH-1:0] expd, cand, free_m;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [NSLOT-1:0] hit_s;
    assign age[g]  = ts - ts_q[g];
    assign expd[g] = vld_q[g] && (age[g] > TS_W'(MAX_DLY));
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign hit_s[s] = (nbr[s] == pix_q[g]);
    end
    assign cand[g]   = vld_q[g] && acc_vld && is_dly && (|hit_s) &&
                       (age[g] >= TS_W'(MIN_DLY)) && (age[g] <= TS_W'(MAX_DLY));
    assign free_m[g] = !vld_q[g] || expd[g];
  end

  logic             m_found, o_found, f_found;
  logic [IDX_W-1:0] m_idx, o_idx, f_idx, ins_idx;
  logic             ins_fire;

  oldest_pick #(.DEPTH(DEPTH), .AGE_W(TS_W), .IDX_W(IDX_W)) u_pick_match (
    .cand(cand), .age(age), .found(m_found), .idx(m_idx));

  oldest_pick #(.DEPTH(DEPTH), .AGE_W(TS_W), .IDX_W(IDX_W)) u_pick_evict (
    .cand(vld_q), .age(age), .found(o_found), .idx(o_idx));

  always_comb begin
    f_found = 1'b0;
    f_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_m[i]) begin
        f_found = 1'b1;
        f_idx   = IDX_W'(i);
      end
    end
  end

  assign ins_fire  = acc_vld && !is_dly;
  assign ins_idx   = f_found ? f_idx : o_idx;
  assign ovf_hit   = ins_fire && !f_found && o_found;
  assign match_vld = m_found;
  assign match_pix = pix_q[m_idx];
  assign match_dly = age[m_idx][DLY_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (expd[i]) vld_q[i] <= 1'b0;
      end
      if (m_found) vld_q[m_idx] <= 1'b0;
      if (ins_fire) vld_q[ins_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      pix_q[ins_idx] <= hit_pix;
      ts_q[ins_idx]  <= ts;
    end
  end

  AST_ONE_OPEN_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(vld_q) <= $countones($past(vld_q)) + 1)); // R3

  AST_PAIRED_WINDOW_CLOSED: assert property (@(posedge clk) disable iff (rst)
    match_vld |=> !vld_q[$past(m_idx)]); // R6

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    AST_STALE_WINDOW_FREED: assert property (@(posedge clk) disable iff (rst)
      (expd[g] && !(ins_fire && ins_idx == IDX_W'(g))) |=> !vld_q[g]); // R7
  end
endmodule

// File: rtl/coinc_trigger.sv
module coinc_trigger #(
  parameter int RINGS   = 6,
  parameter int DEPTH   = 4,
  parameter int TS_W    = 32,
  parameter int MIN_DLY = 1200,
  parameter int MAX_DLY = 4000,
  parameter int CNT_W   = 16,
  localparam int NPIX   = 3 * RINGS * (RINGS + 1) + 1,
  localparam int PIX_W  = $clog2(NPIX + 1),
  localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  ts,
  input  logic             hit_vld,
  input  logic [PIX_W-1:0] hit_pix,
  input  logic             hit_cls,
  output logic             coin_vld,
  output logic [PIX_W-1:0] coin_prompt_pix,
  output logic [PIX_W-1:0] coin_delayed_pix,
  output logic [DLY_W-1:0] coin_delay,
  output logic [CNT_W-1:0] singles_cnt,
  output logic [CNT_W-1:0] ovf_cnt
);
  localparam int NSLOT = coinc_pkg::NSLOT;

  logic                         acc_vld, is_dly;
  logic [NSLOT-1:0][PIX_W-1:0]  nbr;
  logic                         match_vld, ovf_hit;
  logic [PIX_W-1:0]             match_pix;
  logic [DLY_W-1:0]             match_dly;

  assign acc_vld = hit_vld && (32'(hit_pix) < NPIX);
  assign is_dly  = (hit_cls == coinc_pkg::CLS_DELAYED);

  hex_nbr_rom #(.RINGS(RINGS), .NPIX(NPIX), .PIX_W(PIX_W)) u_nbr (
    .pix(hit_pix), .nbr(nbr));

  window_table #(
    .DEPTH(DEPTH), .TS_W(TS_W), .PIX_W(PIX_W),
    .MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)
  ) u_tbl (
    .clk(clk), .rst(rst), .ts(ts), .acc_vld(acc_vld), .is_dly(is_dly),
    .hit_pix(hit_pix), .nbr(nbr), .match_vld(match_vld),
    .match_pix(match_pix), .match_dly(match_dly), .ovf_hit(ovf_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      coin_vld         <= 1'b0;
      coin_prompt_pix  <= '0;
      coin_delayed_pix <= '0;
      coin_delay       <= '0;
      singles_cnt      <= '0;
      ovf_cnt          <= '0;
    end else begin
      coin_vld <= match_vld;
      if (match_vld) begin
        coin_prompt_pix  <= match_pix;
        coin_delayed_pix <= hit_pix;
        coin_delay       <= match_dly;
      end
      if (acc_vld) singles_cnt <= singles_cnt + 1'b1;
      if (ovf_hit) ovf_cnt <= ovf_cnt + 1'b1;
    end
  end

  AST_DELAY_INSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    coin_vld |-> (coin_delay >= DLY_W'(MIN_DLY) && coin_delay <= DLY_W'(MAX_DLY))); // R2

  AST_RECORD_NEEDS_DELAYED: assert property (@(posedge clk) disable iff (rst)
    coin_vld |-> $past(hit_vld && hit_cls == coinc_pkg::CLS_DELAYED)); // R5

  AST_IDLE_KEEPS_SINGLES: assert property (@(posedge clk) disable iff (rst)
    !hit_vld |=> $stable(singles_cnt)); // R8

  AST_DELAYED_NO_EVICT: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && hit_cls == coinc_pkg::CLS_DELAYED) |=> $stable(ovf_cnt)); // R9

  AST_BAD_PIXEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (hit_vld && 32'(hit_pix) >= NPIX) |=> ($stable(singles_cnt) && $stable(ovf_cnt) && !coin_vld)); // R10
endmodule

// File: tb/coinc_trigger_test.sv
module coinc_trigger_test;
  localparam int RINGS = 6, NPIX = 127, DEPTH = 4, MIN_DLY = 1200, MAX_DLY = 4000;
  localparam int PIX_W = 7, DLY_W = 12, CNT_W = 16;

  logic clk = 1'b0;
  logic rst;
  logic [31:0]      ts;
  logic             hit_vld, hit_cls;
  logic [PIX_W-1:0] hit_pix;
  logic             coin_vld;
  logic [PIX_W-1:0] coin_prompt_pix, coin_delayed_pix;
  logic [DLY_W-1:0] coin_delay;
  logic [CNT_W-1:0] singles_cnt, ovf_cnt;

  always #2 clk = ~clk;

  coinc_trigger uut (
    .clk(clk), .rst(rst), .ts(ts), .hit_vld(hit_vld), .hit_pix(hit_pix),
    .hit_cls(hit_cls), .coin_vld(coin_vld), .coin_prompt_pix(coin_prompt_pix),
    .coin_delayed_pix(coin_delayed_pix), .coin_delay(coin_delay),
    .singles_cnt(singles_cnt), .ovf_cnt(ovf_cnt));

  int n_cmp = 0, n_bad = 0;
  int cq [NPIX];
  int cr [NPIX];
  bit          mv   [DEPTH];
  int          mpix [DEPTH];
  logic [31:0] mts  [DEPTH];
  int exp_singles = 0, exp_ovf = 0;
  logic [31:0] T = 32'd1000;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int iab(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit adj(int a, int b);
    int dq, dr;
    dq = cq[b] - cq[a];
    dr = cr[b] - cr[a];
    return (iab(dq) <= 1) && (iab(dr) <= 1) && (iab(dq + dr) <= 1);
  endfunction

  // drive one cycle, update the reference model, check outputs after the edge
  task automatic step(bit v, int pix, bit cls, logic [31:0] t);
    logic [31:0] e [DEPTH];
    logic [31:0] be, oe;
    int best, fr, od;
    bit ok;
    best = -1; fr = -1; od = -1; be = '0; oe = '0;
    ok = v && (pix < NPIX);
    hit_vld = v; hit_pix = PIX_W'(pix); hit_cls = cls; ts = t;
    for (int i = 0; i < DEPTH; i++) e[i] = t - mts[i];
    if (ok) begin
      exp_singles++;
      if (cls) begin
        for (int i = 0; i < DEPTH; i++)
          if (mv[i] && adj(mpix[i], pix) && e[i] >= MIN_DLY && e[i] <= MAX_DLY &&
              (best < 0 || e[i] > be)) begin
            best = i; be = e[i];
          end
      end
    end
    for (int i = 0; i < DEPTH; i++) if (mv[i] && e[i] > MAX_DLY) mv[i] = 1'b0;
    if (best >= 0) mv[best] = 1'b0;
    if (ok && !cls) begin
      for (int i = 0; i < DEPTH; i++) if (!mv[i] && fr < 0) fr = i;
      if (fr < 0) begin
        for (int i = 0; i < DEPTH; i++) if (od < 0 || e[i] > oe) begin od = i; oe = e[i]; end
        fr = od;
        exp_ovf++;
      end
      mv[fr] = 1'b1; mpix[fr] = pix; mts[fr] = t;
    end
    @(posedge clk); #1;
    chk("R4", "coin_vld", 64'(coin_vld), 64'(best >= 0));
    if (best >= 0) begin
      chk("R4", "prompt pixel", 64'(coin_prompt_pix), 64'(mpix[best]));
      chk("R4", "delayed pixel", 64'(coin_delayed_pix), 64'(pix));
      chk("R4", "delay", 64'(coin_delay), 64'(be));
    end
    chk("R8", "singles", 64'(singles_cnt), 64'(exp_singles % 65536));
    chk("R9", "overflow", 64'(ovf_cnt), 64'(exp_ovf % 65536));
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int k;
    int d_list [7];
    k = 0;
    for (int r = -RINGS; r <= RINGS; r++)
      for (int q = -RINGS; q <= RINGS; q++)
        if (iab(q) <= RINGS && iab(r) <= RINGS && iab(q + r) <= RINGS) begin
          cq[k] = q; cr[k] = r; k++;
        end
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 1'b0; mpix[i] = 0; mts[i] = '0; end

    rst = 1'b1; hit_vld = 1'b0; hit_pix = '0; hit_cls = 1'b0; ts = T;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "coin_vld in reset", 64'(coin_vld), 64'd0);
    chk("R11", "singles in reset", 64'(singles_cnt), 64'd0);
    chk("R11", "overflow in reset", 64'(ovf_cnt), 64'd0);
    rst = 1'b0;
    step(1'b0, 0, 1'b0, T);
    chk("R11", "coin_vld after reset", 64'(coin_vld), 64'd0);

    // R1: every prompt pixel against every delayed pixel
    for (int p = 0; p < NPIX; p++)
      for (int d = 0; d < NPIX; d++) begin
        step(1'b1, p, 1'b0, T);
        step(1'b1, d, 1'b1, T + 1500);
        chk("R1", "pair formed", 64'(coin_vld), 64'(adj(p, d)));
        T += 6000;
      end

    // R2: window edges; R5: prompt gives no record
    d_list = '{1199, 1200, 1201, 2500, 3999, 4000, 4001};
    foreach (d_list[i]) begin
      step(1'b1, 60, 1'b0, T);
      chk("R5", "record after prompt", 64'(coin_vld), 64'd0);
      step(1'b1, 60, 1'b1, T + d_list[i]);
      chk("R2", "in window", 64'(coin_vld), 64'(d_list[i] >= 1200 && d_list[i] <= 4000));
      T += 10000;
    end

    // R6: oldest qualifying window wins, then it is closed
    step(1'b1, 10, 1'b0, T);
    step(1'b1, 11, 1'b0, T + 100);
    step(1'b1, 10, 1'b1, T + 1500);
    chk("R6", "first winner pixel", 64'(coin_prompt_pix), 64'd10);
    chk("R6", "first winner delay", 64'(coin_delay), 64'd1500);
    step(1'b1, 10, 1'b1, T + 1600);
    chk("R6", "second winner pixel", 64'(coin_prompt_pix), 64'd11);
    chk("R6", "second winner delay", 64'(coin_delay), 64'd1500);
    step(1'b1, 10, 1'b1, T + 1700);
    chk("R6", "no third pair", 64'(coin_vld), 64'd0);
    T += 10000;

    // R3: four windows open together, each pairs
    for (int i = 0; i < 4; i++) step(1'b1, 30 * i, 1'b0, T + i);
    chk("R3", "no overflow at four", 64'(ovf_cnt), 64'(exp_ovf));
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 30 * i, 1'b1, T + 2000 + i);
      chk("R3", "slot pairs", 64'(coin_vld), 64'd1);
    end
    T += 10000;

    // R9: fifth window evicts the oldest
    k = exp_ovf;
    for (int i = 0; i < 5; i++) step(1'b1, 30 * i, 1'b0, T + i);
    chk("R9", "overflow step", 64'(ovf_cnt), 64'(k + 1));
    step(1'b1, 0, 1'b1, T + 2000);
    chk("R9", "evicted window gone", 64'(coin_vld), 64'd0);
    step(1'b1, 30, 1'b1, T + 2001);
    chk("R9", "survivor pairs", 64'(coin_vld), 64'd1);
    T += 10000;

    // R7: expired windows free their slots
    for (int i = 0; i < 4; i++) step(1'b1, 30 * i, 1'b0, T + i);
    k = exp_ovf;
    step(1'b0, 0, 1'b0, T + 4004);
    step(1'b1, 120, 1'b0, T + 4005);
    chk("R7", "no overflow after expiry", 64'(ovf_cnt), 64'(k));
    T += 10000;

    // R10: out-of-range pixel ignored
    k = exp_singles;
    step(1'b1, 127, 1'b0, T);
    chk("R10", "singles unchanged", 64'(singles_cnt), 64'(k % 65536));
    step(1'b1, 126, 1'b1, T + 1500);
    chk("R10", "no pair from bad pixel", 64'(coin_vld), 64'd0);
    step(1'b1, 127, 1'b1, T + 1600);
    chk("R10", "no record from bad delayed", 64'(coin_vld), 64'd0);
    step(1'b0, 0, 1'b0, T + 1700);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule